// File: doc/BRIEF.md
# Windowed Watchdog with Error Accumulator

The block watches a single refresh pulse and judges each one against a timing window measured in base clock cycles. Three limits set the window: a refresh that comes too soon is an early error, one that comes after the open part of the window is a late error, and no refresh at all by the final limit is a non-response. Both kinds of timing error are kept apart and shown on sticky flags. Either kind can be set to log only or to count toward a reset.

Counted errors go into an accumulator that a supervisor can read. A correct in-window refresh pays one error back. A reset request is raised when the accumulator reaches a programmable tolerance, or at once on a non-response. The request lasts a fixed number of cycles, after which the block starts a fresh window with a clean record. A limit set that is not in order stops monitoring and raises a configuration flag.

Top module: `win_watchdog`

## Requirements
- R1: The window count is 0 in the first cycle after a restart and rises by one each cycle. A refresh sampled while the count is below `lim_lo_i` sets `early_err_o` in the next cycle, and the flag stays set.
- R2: A refresh sampled while the count is above `lim_hi_i` sets `late_err_o` in the next cycle, and the flag stays set. A refresh sampled exactly at the count `lim_end_i` is late.
- R3: If no refresh is sampled in the cycle where the count equals `lim_end_i`, `wd_rst_o` goes high in the next cycle, whatever the accumulator holds.
- R4: A counted early or late error raises `err_cnt_o` by one in the next cycle. When the new value reaches `err_tol_i`, `wd_rst_o` goes high in that same cycle.
- R5: With `early_counts_i` low, an early refresh only sets its flag and leaves `err_cnt_o` unchanged. `late_counts_i` does the same for late refreshes.
- R6: A refresh sampled with the count from `lim_lo_i` to `lim_hi_i` inclusive sets no flag and lowers `err_cnt_o` by one, stopping at 0.
- R7: Every refresh that is judged, whether valid or not, restarts the count from 0. Refreshes spaced inside the terminal limit therefore never cause a non-response reset.
- R8: `wd_rst_o` stays high for exactly `HOLD_CYC` cycles (4 by default). Refresh pulses during that time are ignored. When it falls, `err_cnt_o`, both flags and the count are 0.
- R9: `cfg_err_o` is high unless `lim_lo_i < lim_hi_i < lim_end_i` and `err_tol_i >= 1`. While it is high the count is held at 0, refreshes are not judged and no reset request starts.
- R10: After `rst_n` is released, `early_err_o`, `late_err_o`, `err_cnt_o` and `wd_rst_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; all limits count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_i | input | 1 | Refresh pulse, sampled on each rising edge |
| lim_lo_i | input | CNT_W | Lowest count accepted as a valid refresh |
| lim_hi_i | input | CNT_W | Highest count accepted as a valid refresh |
| lim_end_i | input | CNT_W | Count at which a missing refresh is a non-response |
| err_tol_i | input | ERR_W | Number of accumulated errors that requests a reset |
| early_counts_i | input | 1 | Early errors add to the accumulator when high |
| late_counts_i | input | 1 | Late errors add to the accumulator when high |
| early_err_o | output | 1 | Sticky flag: an early refresh was seen |
| late_err_o | output | 1 | Sticky flag: a late refresh was seen |
| err_cnt_o | output | ERR_W | Current accumulator value |
| wd_rst_o | output | 1 | Reset request |
| cfg_err_o | output | 1 | Limit set or tolerance is invalid; monitoring is held off |

## Verification
The bench aims at the window edges: counts exactly at the lower and upper limits must be valid, one cycle either side must not be, and a refresh at the terminal count must be judged late rather than time out. A design that was off by one cycle in its count would flag these boundary refreshes wrongly. It would also raise the non-response request a cycle early or late. A design that ignored the log-only controls, or that let the accumulator wrap below zero, would show a wrong `err_cnt_o`. The bench also pulses refresh during the reset hold and runs with a disordered limit set. A design that restarted the hold, kept stale flags, or went on judging refreshes under a bad configuration would fail those checks.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

   typedef enum logic [1:0] {
      VERDICT_NONE  = 2'd0,
      VERDICT_EARLY = 2'd1,
      VERDICT_OK    = 2'd2,
      VERDICT_LATE  = 2'd3
   } verdict_e;

   typedef enum logic {
      PH_WATCH = 1'b0,
      PH_HOLD  = 1'b1
   } phase_e;

endpackage

// File: rtl/wwdt_cfg_check.sv
module wwdt_cfg_check #(
   parameter int CNT_W   = 16,
   parameter int ERR_W   = 4,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] lim_lo_i,
   input  logic [CNT_W-1:0] lim_hi_i,
   input  logic [CNT_W-1:0] lim_end_i,
   input  logic [ERR_W-1:0] err_tol_i,
   output logic             bad_o
);

   logic bad_now;

   always_comb begin
      bad_now = 1'b0;
      if (!(lim_lo_i < lim_hi_i)) bad_now = 1'b1;
      if (!(lim_hi_i < lim_end_i)) bad_now = 1'b1;
      if (err_tol_i == '0) bad_now = 1'b1;
   end

   generate
      if (REG_OUT) begin : g_reg
         logic bad_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bad_q <= 1'b1;
            else        bad_q <= bad_now;
         end
         assign bad_o = bad_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign bad_o = bad_now;
      end
   endgenerate

endmodule

// File: rtl/wwdt_window.sv
module wwdt_window
   import wwdt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             refresh_i,
   input  logic [CNT_W-1:0] lim_lo_i,
   input  logic [CNT_W-1:0] lim_hi_i,
   input  logic [CNT_W-1:0] lim_end_i,
   output verdict_e         verdict_o,
   output logic             expire_o,
   output logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!run_i)         cnt_q <= '0;
      else if (refresh_i)      cnt_q <= '0;
      else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
   end

   always_comb begin
      verdict_o = VERDICT_NONE;
      if (run_i && refresh_i) begin
         if (cnt_q < lim_lo_i)      verdict_o = VERDICT_EARLY;
         else if (cnt_q > lim_hi_i) verdict_o = VERDICT_LATE;
         else                       verdict_o = VERDICT_OK;
      end
   end

   assign expire_o = run_i && !refresh_i && (cnt_q == lim_end_i);
   assign cnt_o    = cnt_q;

   AST_RESTART_ON_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
      run_i && refresh_i |=> cnt_q == '0); // R7
   AST_COUNT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      run_i && !refresh_i && cnt_q != CNT_TOP |=> cnt_q == $past(cnt_q) + 1'b1); // R1

endmodule

// File: rtl/wwdt_accum.sv
module wwdt_accum #(
   parameter int ERR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             inc_i,
   input  logic             dec_i,
   input  logic [ERR_W-1:0] tol_i,
   output logic [ERR_W-1:0] acc_o,
   output logic             trip_o
);

   localparam int             SUM_W   = ERR_W + 1;
   localparam logic [ERR_W-1:0] ACC_TOP = {ERR_W{1'b1}};

   logic [ERR_W-1:0] acc_q;
   logic [SUM_W-1:0] acc_next_w;

   assign acc_next_w = {1'b0, acc_q} + SUM_W'(1);
   assign trip_o     = inc_i && (acc_next_w >= {1'b0, tol_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     acc_q <= '0;
      else if (clear_i)               acc_q <= '0;
      else if (inc_i) begin
         if (acc_q != ACC_TOP)        acc_q <= acc_q + 1'b1;
      end
      else if (dec_i && acc_q != '0)  acc_q <= acc_q - 1'b1;
   end

   assign acc_o = acc_q;

   AST_ACC_PAYBACK: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i && !inc_i && dec_i && acc_q != '0 |=> acc_q == $past(acc_q) - 1'b1); // R6
   AST_ACC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i && !inc_i && dec_i && acc_q == '0 |=> acc_q == '0); // R6
   AST_ACC_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i && inc_i && acc_q != ACC_TOP |=> acc_q == $past(acc_q) + 1'b1); // R4

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
   import wwdt_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int ERR_W    = 4,
   parameter int HOLD_CYC = 4,
   parameter bit CFG_REG  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             refresh_i,
   input  logic [CNT_W-1:0] lim_lo_i,
   input  logic [CNT_W-1:0] lim_hi_i,
   input  logic [CNT_W-1:0] lim_end_i,
   input  logic [ERR_W-1:0] err_tol_i,
   input  logic             early_counts_i,
   input  logic             late_counts_i,
   output logic             early_err_o,
   output logic             late_err_o,
   output logic [ERR_W-1:0] err_cnt_o,
   output logic             wd_rst_o,
   output logic             cfg_err_o
);

   localparam int            HOLD_W    = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
   localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYC - 1);

   generate
      if (CNT_W < 2) begin : g_bad_cnt_w
         $error("win_watchdog: CNT_W must be at least 2");
      end
      if (ERR_W < 1) begin : g_bad_err_w
         $error("win_watchdog: ERR_W must be at least 1");
      end
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("win_watchdog: HOLD_CYC must be at least 1");
      end
   endgenerate

   phase_e            phase_q;
   logic [HOLD_W-1:0] hold_q;
   logic              cfg_bad;
   logic              run;
   verdict_e          verdict;
   logic              expire;
   logic [CNT_W-1:0]  win_cnt;
   logic              acc_inc;
   logic              acc_dec;
   logic              acc_trip;
   logic              hold_done;
   logic              go_hold;
   logic              early_q;
   logic              late_q;

   wwdt_cfg_check #(
      .CNT_W   (CNT_W),
      .ERR_W   (ERR_W),
      .REG_OUT (CFG_REG)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .lim_lo_i  (lim_lo_i),
      .lim_hi_i  (lim_hi_i),
      .lim_end_i (lim_end_i),
      .err_tol_i (err_tol_i),
      .bad_o     (cfg_bad)
   );

   assign run = !cfg_bad && (phase_q == PH_WATCH);

   wwdt_window #(
      .CNT_W (CNT_W)
   ) u_window (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run),
      .refresh_i (refresh_i),
      .lim_lo_i  (lim_lo_i),
      .lim_hi_i  (lim_hi_i),
      .lim_end_i (lim_end_i),
      .verdict_o (verdict),
      .expire_o  (expire),
      .cnt_o     (win_cnt)
   );

   assign acc_inc = ((verdict == VERDICT_EARLY) && early_counts_i)
                 || ((verdict == VERDICT_LATE) && late_counts_i);
   assign acc_dec = (verdict == VERDICT_OK);
   assign hold_done = (phase_q == PH_HOLD) && (hold_q == '0);

   wwdt_accum #(
      .ERR_W (ERR_W)
   ) u_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (hold_done),
      .inc_i   (acc_inc),
      .dec_i   (acc_dec),
      .tol_i   (err_tol_i),
      .acc_o   (err_cnt_o),
      .trip_o  (acc_trip)
   );

   assign go_hold = expire || acc_trip;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_WATCH;
         hold_q  <= '0;
      end else if (phase_q == PH_WATCH) begin
         if (go_hold) begin
            phase_q <= PH_HOLD;
            hold_q  <= HOLD_LAST;
         end
      end else if (hold_q == '0) begin
         phase_q <= PH_WATCH;
      end else begin
         hold_q <= hold_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         early_q <= 1'b0;
         late_q  <= 1'b0;
      end else if (hold_done) begin
         early_q <= 1'b0;
         late_q  <= 1'b0;
      end else begin
         if (verdict == VERDICT_EARLY) early_q <= 1'b1;
         if (verdict == VERDICT_LATE)  late_q  <= 1'b1;
      end
   end

   assign early_err_o = early_q;
   assign late_err_o  = late_q;
   assign wd_rst_o    = (phase_q == PH_HOLD);
   assign cfg_err_o   = cfg_bad;

   AST_EARLY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      run && refresh_i && win_cnt < lim_lo_i |=> early_err_o); // R1
   AST_LATE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      run && refresh_i && win_cnt > lim_hi_i |=> late_err_o); // R2
   AST_NO_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
      run && !refresh_i && win_cnt == lim_end_i |=> wd_rst_o); // R3
   AST_TOLERANCE_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      !wd_rst_o && acc_inc && ({1'b0, err_cnt_o} + 1'b1) >= {1'b0, err_tol_i} |=> wd_rst_o); // R4
   AST_LOG_ONLY_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      verdict == VERDICT_EARLY && !early_counts_i |=> $stable(err_cnt_o)); // R5
   AST_LOG_ONLY_LATE: assert property (@(posedge clk) disable iff (!rst_n)
      verdict == VERDICT_LATE && !late_counts_i |=> $stable(err_cnt_o)); // R5
   AST_CLEAN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wd_rst_o) |-> err_cnt_o == '0 && !early_err_o && !late_err_o && win_cnt == '0); // R8
   AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err_o && !wd_rst_o |=> !wd_rst_o); // R9
   AST_CFG_FLAGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err_o && !wd_rst_o |=> $stable(early_err_o) && $stable(late_err_o)); // R9

endmodule

// File: tb/win_watchdog_bench.sv
module win_watchdog_bench;

   localparam int CNT_W = 16;
   localparam int ERR_W = 4;
   localparam int HOLD  = 4;
   localparam int LO    = 4;
   localparam int HI    = 8;
   localparam int TE    = 12;
   localparam int TOL   = 3;

   typedef struct {
      bit    early;
      bit    late;
      bit    rst;
      int    acc;
      string req;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             refresh_i = 1'b0;
   logic [CNT_W-1:0] lim_lo_i = CNT_W'(LO);
   logic [CNT_W-1:0] lim_hi_i = CNT_W'(HI);
   logic [CNT_W-1:0] lim_end_i = CNT_W'(TE);
   logic [ERR_W-1:0] err_tol_i = ERR_W'(TOL);
   logic             early_counts_i = 1'b1;
   logic             late_counts_i = 1'b1;
   logic             early_err_o;
   logic             late_err_o;
   logic [ERR_W-1:0] err_cnt_o;
   logic             wd_rst_o;
   logic             cfg_err_o;

   int   n_checks = 0;
   int   n_fails  = 0;
   exp_t sb_q[$];

   bit m_early = 0;
   bit m_late  = 0;
   int m_acc   = 0;

   always #2.5 clk = ~clk;

   win_watchdog #(
      .CNT_W    (CNT_W),
      .ERR_W    (ERR_W),
      .HOLD_CYC (HOLD),
      .CFG_REG  (1'b0)
   ) u_win_watchdog (
      .clk            (clk),
      .rst_n          (rst_n),
      .refresh_i      (refresh_i),
      .lim_lo_i       (lim_lo_i),
      .lim_hi_i       (lim_hi_i),
      .lim_end_i      (lim_end_i),
      .err_tol_i      (err_tol_i),
      .early_counts_i (early_counts_i),
      .late_counts_i  (late_counts_i),
      .early_err_o    (early_err_o),
      .late_err_o     (late_err_o),
      .err_cnt_o      (err_cnt_o),
      .wd_rst_o       (wd_rst_o),
      .cfg_err_o      (cfg_err_o)
   );

   task automatic check(input int act, input int exp, input string req);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push(input bit rst, input string req);
      exp_t it;
      it.early = m_early;
      it.late  = m_late;
      it.rst   = rst;
      it.acc   = m_acc;
      it.req   = req;
      sb_q.push_back(it);
   endtask

   // monitor: one expectation per rising edge, compared 1 ns after it
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            check(int'(early_err_o), int'(it.early), {it.req, " early flag"});
            check(int'(late_err_o),  int'(it.late),  {it.req, " late flag"});
            check(int'(err_cnt_o),   it.acc,         {it.req, " error count"});
            check(int'(wd_rst_o),    int'(it.rst),   {it.req, " reset request"});
         end
      end
   end

   // driver: idle g cycles, then a one-cycle refresh judged at count g
   task automatic gap_refresh(input int g, input string req);
      bit rst = 0;
      repeat (g) @(negedge clk);
      if (g < LO) begin
         m_early = 1;
         if (early_counts_i) begin
            m_acc++;
            rst = (m_acc >= TOL);
         end
      end else if (g > HI) begin
         m_late = 1;
         if (late_counts_i) begin
            m_acc++;
            rst = (m_acc >= TOL);
         end
      end else if (m_acc > 0) begin
         m_acc--;
      end
      push(rst, req);
      refresh_i = 1'b1;
      @(negedge clk);
      refresh_i = 1'b0;
   endtask

   task automatic ride_hold(input bit poke, input string req);
      int n = 0;
      while (wd_rst_o && n < 50) begin
         refresh_i = poke && (n == 1);
         n++;
         @(negedge clk);
      end
      refresh_i = 1'b0;
      check(n, HOLD, {req, " hold length"});
      m_early = 0;
      m_late  = 0;
      m_acc   = 0;
      check(int'(early_err_o), 0, {req, " early cleared"});
      check(int'(late_err_o),  0, {req, " late cleared"});
      check(int'(err_cnt_o),   0, {req, " count cleared"});
   endtask

   initial begin
      #2_000_000;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
   end

   initial begin
      int rst_seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10: reset state
      check(int'(early_err_o), 0, "R10 early");
      check(int'(late_err_o),  0, "R10 late");
      check(int'(err_cnt_o),   0, "R10 count");
      check(int'(wd_rst_o),    0, "R10 reset");
      check(int'(cfg_err_o),   0, "R9 good config");

      // R6: valid refreshes, including both window edges
      gap_refresh(6, "R6 mid window");
      gap_refresh(LO, "R6 lower edge");
      gap_refresh(HI, "R6 upper edge");

      // R1, R2, R4, R6 accumulate and pay back
      gap_refresh(LO - 1, "R1 early by one");
      gap_refresh(HI + 1, "R2 late by one");
      gap_refresh(5, "R6 payback");
      gap_refresh(0, "R1 back to back");
      gap_refresh(TE, "R2 late at terminal, R4 tolerance trip");
      ride_hold(1'b1, "R8");
      gap_refresh(6, "R8 fresh window");

      // R5: log-only early and late
      early_counts_i = 1'b0;
      gap_refresh(2, "R5 early log only");
      late_counts_i = 1'b0;
      gap_refresh(10, "R5 late log only");
      gap_refresh(6, "R5 valid after log only");
      early_counts_i = 1'b1;
      late_counts_i  = 1'b1;

      // R7: restarts keep the terminal limit away
      gap_refresh(HI, "R7 restart a");
      gap_refresh(HI, "R7 restart b");
      gap_refresh(HI, "R7 restart c");
      gap_refresh(7, "R7 restart d");

      // R3: no-response timeout
      gap_refresh(6, "R3 setup");
      repeat (TE - 1) @(negedge clk);
      push(1'b0, "R3 one before terminal");
      @(negedge clk);
      push(1'b1, "R3 terminal expiry");
      @(negedge clk);
      ride_hold(1'b0, "R3 R8");

      // R9: disordered limits
      gap_refresh(3, "R9 setup early");
      lim_hi_i = CNT_W'(LO);
      @(negedge clk);
      check(int'(cfg_err_o), 1, "R9 lower equals upper");
      repeat (2) @(negedge clk);
      refresh_i = 1'b1;
      @(negedge clk);
      refresh_i = 1'b0;
      rst_seen = 0;
      repeat (TE + 8) begin
         @(negedge clk);
         if (wd_rst_o) rst_seen++;
      end
      check(rst_seen, 0, "R9 no reset while bad");
      check(int'(err_cnt_o), m_acc, "R9 refresh not judged");
      check(int'(late_err_o), 0, "R9 no late flag");
      lim_hi_i = CNT_W'(HI);
      err_tol_i = '0;
      @(negedge clk);
      check(int'(cfg_err_o), 1, "R9 zero tolerance");
      err_tol_i = ERR_W'(TOL);
      @(negedge clk);
      check(int'(cfg_err_o), 0, "R9 restored");
      gap_refresh(5, "R9 resumes at count zero");

      repeat (3) @(negedge clk);
      check(sb_q.size(), 0, "scoreboard drained");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
   end

endmodule